// File: doc/BRIEF.md
# Streaming Complex Adder with Halving

This block adds two streams of complex samples, one pair of samples at a time. Every beat on each input carries one complex value in a 32-bit word: two 16-bit two's-complement parts, one real and one imaginary. The block sums the real parts and the imaginary parts separately and returns the complex result on a single output stream in the same word layout.

Adding two full-scale 16-bit values needs 17 bits. To keep the output at 16 bits per part without wrap, each operand is sign-extended by one bit before the add. The 17-bit sum is then shifted right arithmetically by one, which drops its least significant bit. The result is half the true sum, rounded toward negative infinity, so it always fits the output range.

The two input streams are joined: a pair of beats is taken in one cycle, only when both sides offer data and the registered output stage can take a new result. Output data, valid and the end-of-packet flag are registered, and backpressure from the consumer stalls both inputs.

Top module: `cplx_stream_adder`

## Requirements
- R1: In every word, bits 15:0 hold the real part and bits 31:16 hold the imaginary part, each 16-bit two's-complement. Each output part equals bits 16:1 of the 17-bit sum of the two sign-extended input parts of that field.
- R2: Results never wrap. Two positive operands give a non-negative result, and two negative operands give a negative result. Real 32000 plus real 32000 gives 0x7D00 (32000) in bits 15:0, and the imaginary field behaves the same way.
- R3: Halving rounds toward negative infinity. -1 + 0 gives -1 (0xFFFF), 1 + 0 gives 0, 32767 + (-32768) gives -1, and -32768 + -32768 gives -32768 (0x8000).
- R4: Both inputs are consumed in the same cycle or neither is consumed. A pair is consumed only when both input valids are high and the output register is empty or is being read in that cycle.
- R5: The ready of input A equals input B valid AND (output not valid OR output ready), so it does not depend on input A valid. The ready of input B is defined the same way with input A valid.
- R6: While output valid is high and output ready is low, output valid stays high and output data and last stay unchanged.
- R7: Output last is the OR of the two last flags of the consumed input pair.
- R8: A low active-low reset, sampled at a clock edge, clears output valid at that edge and drops a pending result.
- R9: A pair consumed at a clock edge appears at the output from that same edge, with output valid high one cycle after it was offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| aTvalid | input | 1 | Input A beat valid |
| aTready | output | 1 | Input A ready |
| aTdata | input | 32 | Input A complex sample (imag 31:16, real 15:0) |
| aTlast | input | 1 | Input A end of packet |
| bTvalid | input | 1 | Input B beat valid |
| bTready | output | 1 | Input B ready |
| bTdata | input | 32 | Input B complex sample (imag 31:16, real 15:0) |
| bTlast | input | 1 | Input B end of packet |
| mTvalid | output | 1 | Output beat valid |
| mTready | input | 1 | Output ready from consumer |
| mTdata | output | 32 | Halved complex sum (imag 31:16, real 15:0) |
| mTlast | output | 1 | Output end of packet |

## Verification
The bench builds the block with its default part width of 16 bits, which is the word layout the requirements fix. At this width the bench can drive the extreme operands directly: both full-scale positive, both full-scale negative, mixed signs and odd sums. These cases exercise the sign extension and the floor rounding at exactly the points where a missing extension bit would wrap. Random valids on both inputs and random consumer ready exercise the handshake join, stalls with a held result, and draining and refilling the output register in the same cycle.

// File: rtl/cplx_add_pkg.sv
package cplx_add_pkg;
  // Strobes passed from the handshake control to the datapath.
  typedef struct packed {
    logic load;   // capture a new halved sum this cycle
    logic clear;  // drop registered contents (reset)
  } addCtrl_t;
endpackage

// File: rtl/cplx_add_ctrl.sv
module cplx_add_ctrl
  import cplx_add_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     aValid,
  input  logic     bValid,
  input  logic     mReady,
  output logic     aReady,
  output logic     bReady,
  output logic     mValid,
  output addCtrl_t ctrl
);
  logic canLoad;
  logic pairFire;

  // Output slot is free when empty or being drained this cycle.
  assign canLoad  = !mValid || mReady;
  // Each ready looks only at the opposite valid (R5).
  assign aReady   = bValid && canLoad;
  assign bReady   = aValid && canLoad;
  assign pairFire = aValid && bValid && canLoad;

  assign ctrl.load  = pairFire;
  assign ctrl.clear = !rstN;

  always_ff @(posedge clk) begin
    if (!rstN)          mValid <= 1'b0;
    else if (pairFire)  mValid <= 1'b1;
    else if (mReady)    mValid <= 1'b0;
  end

  // R4: the two inputs are consumed together or not at all.
  p_join_r4: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && aReady) |-> (bValid && bReady));

  // R9: a consumed pair is presented on the next cycle.
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && aReady) |=> mValid);

  // R6: a stalled result is not withdrawn.
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> mValid);
endmodule

// File: rtl/cplx_add_dpath.sv
module cplx_add_dpath
  import cplx_add_pkg::*;
#(
  parameter int PART_W = 16
) (
  input  logic                clk,
  input  addCtrl_t            ctrl,
  input  logic [2*PART_W-1:0] aData,
  input  logic                aLast,
  input  logic [2*PART_W-1:0] bData,
  input  logic                bLast,
  output logic [2*PART_W-1:0] outData,
  output logic                outLast
);
  localparam int WORD_W = 2 * PART_W;
  localparam int LANES  = 2;

  logic [WORD_W-1:0] halfSum;

  // One lane per complex component: sign-extend, add, arithmetic halve.
  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic signed [PART_W-1:0] aPart;
    logic signed [PART_W-1:0] bPart;
    logic signed [PART_W:0]   aExt;
    logic signed [PART_W:0]   bExt;

    assign aPart = aData[k*PART_W +: PART_W];
    assign bPart = bData[k*PART_W +: PART_W];
    assign aExt  = {aPart[PART_W-1], aPart};
    assign bExt  = {bPart[PART_W-1], bPart};
    assign halfSum[k*PART_W +: PART_W] = PART_W'((aExt + bExt) >>> 1);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      outData <= '0;
      outLast <= 1'b0;
    end else if (ctrl.load) begin
      outData <= halfSum;
      outLast <= aLast || bLast;
    end
  end

  // R2: two non-negative real parts never produce a negative result.
  p_no_wrap_pos_r2: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.load && !aData[PART_W-1] && !bData[PART_W-1]) |=> !outData[PART_W-1]);

  // R2: two negative imaginary parts never produce a non-negative result.
  p_no_wrap_neg_r2: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.load && aData[WORD_W-1] && bData[WORD_W-1]) |=> outData[WORD_W-1]);
endmodule

// File: rtl/cplx_stream_adder.sv
module cplx_stream_adder
  import cplx_add_pkg::*;
#(
  parameter int PART_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                aTvalid,
  output logic                aTready,
  input  logic [2*PART_W-1:0] aTdata,
  input  logic                aTlast,
  input  logic                bTvalid,
  output logic                bTready,
  input  logic [2*PART_W-1:0] bTdata,
  input  logic                bTlast,
  output logic                mTvalid,
  input  logic                mTready,
  output logic [2*PART_W-1:0] mTdata,
  output logic                mTlast
);
  addCtrl_t ctrl;

  cplx_add_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .aValid (aTvalid),
    .bValid (bTvalid),
    .mReady (mTready),
    .aReady (aTready),
    .bReady (bTready),
    .mValid (mTvalid),
    .ctrl   (ctrl)
  );

  cplx_add_dpath #(.PART_W(PART_W)) u_dpath (
    .clk     (clk),
    .ctrl    (ctrl),
    .aData   (aTdata),
    .aLast   (aTlast),
    .bData   (bTdata),
    .bLast   (bTlast),
    .outData (mTdata),
    .outLast (mTlast)
  );

  // R6: a stalled beat keeps its payload.
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> ($stable(mTdata) && $stable(mTlast)));
endmodule

// File: tb/cplx_stream_adder_tb.sv
module cplx_stream_adder_tb;
  localparam int PW = 16;
  localparam int WW = 2 * PW;
  localparam int NDIR = 6;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aTvalid = 1'b0, bTvalid = 1'b0, mTready = 1'b0;
  logic aTlast = 1'b0, bTlast = 1'b0;
  logic [WW-1:0] aTdata = '0, bTdata = '0;
  logic aTready, bTready, mTvalid, mTlast;
  logic [WW-1:0] mTdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  cplx_stream_adder #(.PART_W(PW)) u_dut (
    .clk(clk), .rstN(rstN),
    .aTvalid(aTvalid), .aTready(aTready), .aTdata(aTdata), .aTlast(aTlast),
    .bTvalid(bTvalid), .bTready(bTready), .bTdata(bTdata), .bTlast(bTlast),
    .mTvalid(mTvalid), .mTready(mTready), .mTdata(mTdata), .mTlast(mTlast)
  );

  // Floor of half the true sum of two 16-bit signed parts.
  function automatic logic [PW-1:0] halfPart(input logic [PW-1:0] x, input logic [PW-1:0] y);
    int s;
    s = int'($signed(x)) + int'($signed(y));
    if (s < 0 && (s % 2) != 0) s = (s - 1) / 2;
    else s = s / 2;
    return s[PW-1:0];
  endfunction

  function automatic logic [WW-1:0] expWord(input logic [WW-1:0] x, input logic [WW-1:0] y);
    return {halfPart(x[WW-1:PW], y[WW-1:PW]), halfPart(x[PW-1:0], y[PW-1:0])};
  endfunction

  // Directed corners: {imag, real}.
  function automatic logic [WW-1:0] dirA(input int i);
    case (i)
      0: return {16'sd32000, 16'sd32000};
      1: return {16'h0000, 16'hFFFF};
      2: return {16'h8000, 16'h8000};
      3: return {16'h0001, 16'h0001};
      4: return {16'h7FFF, 16'h7FFF};
      default: return {16'h8000, 16'h7FFF};
    endcase
  endfunction
  function automatic logic [WW-1:0] dirB(input int i);
    case (i)
      0: return {16'sd32000, 16'sd32000};
      1: return {16'hFFFF, 16'h0000};
      2: return {16'h8000, 16'h8000};
      3: return {16'h0000, 16'h0000};
      4: return {16'h8000, 16'h8000};
      default: return {16'h7FFF, 16'h8000};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected output queue.
  logic [WW-1:0] qData [0:7];
  logic          qLast [0:7];
  int qHead = 0, qTail = 0;

  logic prevStall = 1'b0;
  logic [WW-1:0] prevData = '0;
  logic prevLast = 1'b0;
  logic aFire, bFire;
  int dirIdx = 0;
  bit directed = 1'b1;
  bit done = 1'b0;

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state.
    check(mTvalid == 1'b0, "R8", "valid after reset", {31'd0, mTvalid}, '0);
    rstN = 1'b1;
    mTready = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // R5: each ready built only from the other side's valid.
      check(aTready == (bTvalid && (!mTvalid || mTready)), "R5", "aTready",
            {31'd0, aTready}, {31'd0, (bTvalid && (!mTvalid || mTready))});
      check(bTready == (aTvalid && (!mTvalid || mTready)), "R5", "bTready",
            {31'd0, bTready}, {31'd0, (aTvalid && (!mTvalid || mTready))});
      aFire = aTvalid && aTready;
      bFire = bTvalid && bTready;
      check(aFire == bFire, "R4", "joined consume", {31'd0, aFire}, {31'd0, bFire});
      // R6: stalled beat held.
      if (prevStall) begin
        check(mTvalid == 1'b1, "R6", "valid held", {31'd0, mTvalid}, 1);
        check(mTdata == prevData && mTlast == prevLast, "R6", "data held", mTdata, prevData);
      end
      prevStall = mTvalid && !mTready;
      prevData  = mTdata;
      prevLast  = mTlast;
      // Drain check: R1/R2/R3 on data, R7 on last, R9 on presence.
      if (mTvalid && mTready) begin
        if (qHead == qTail) begin
          check(1'b0, "R9", "unexpected output beat", mTdata, '0);
        end else begin
          check(mTdata == qData[qHead[2:0]], directed ? "R2/R3" : "R1", "sum",
                mTdata, qData[qHead[2:0]]);
          check(mTlast == qLast[qHead[2:0]], "R7", "last",
                {31'd0, mTlast}, {31'd0, qLast[qHead[2:0]]});
          qHead++;
        end
      end else if (!mTvalid) begin
        check(qHead == qTail, "R9", "missing output beat", 0, 1);
      end
      if (aFire && bFire) begin
        qData[qTail[2:0]] = expWord(aTdata, bTdata);
        qLast[qTail[2:0]] = aTlast || bTlast;
        qTail++;
      end

      @(posedge clk);
      #1;
      if (directed) begin
        if (aFire) dirIdx++;
        if (dirIdx >= NDIR) begin
          directed = 1'b0;
        end else begin
          aTvalid = 1'b1; bTvalid = 1'b1; mTready = 1'b1;
          aTdata = dirA(dirIdx); bTdata = dirB(dirIdx);
          aTlast = 1'b0; bTlast = (dirIdx == 2);
        end
      end
      if (!directed) begin
        if (!(aTvalid && !aFire)) begin
          aTvalid = ($urandom % 4) != 0;
          aTdata  = $urandom;
          aTlast  = ($urandom % 5) == 0;
        end
        if (!(bTvalid && !bFire)) begin
          bTvalid = ($urandom % 4) != 0;
          bTdata  = $urandom;
          bTlast  = ($urandom % 5) == 0;
        end
        mTready = ($urandom % 3) != 0;
      end
    end

    // R8: reset while a result is stalled drops it.
    aTvalid = 1'b1; bTvalid = 1'b1; mTready = 1'b0;
    aTdata = {16'h1234, 16'h0100}; bTdata = {16'h0002, 16'h0200};
    @(posedge clk); #1;
    aTvalid = 1'b0; bTvalid = 1'b0;
    @(negedge clk);
    check(mTvalid == 1'b1, "R8", "pending before reset", {31'd0, mTvalid}, 1);
    @(posedge clk); #1;
    rstN = 1'b0;
    @(posedge clk); #1;
    check(mTvalid == 1'b0, "R8", "valid cleared by reset", {31'd0, mTvalid}, 0);
    rstN = 1'b1; mTready = 1'b1;
    @(posedge clk); #1;
    check(mTvalid == 1'b0, "R8", "dropped beat stays gone", {31'd0, mTvalid}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule